// File: doc/BRIEF.md
# Supervisory Reset Pulse Controller

This block generates the system reset for a chip from two digitised inputs: the output of a supply-OK comparator and the sensed level of a shared, wired-AND reset line. It only ever pulls that line low through an output-enable (`pullLow`); the pad, its pull-up and the comparator sit outside. All pulse timing is counted in ticks of a slow 5 kHz oscillator, delivered as a one-cycle strobe (`slowTick`) in the system clock domain.

After reset of the block, and after any supply drop that survives a glitch filter of `GLITCH_CYCLES` system clocks, the line is held low until the supply has stayed good for `HOLD_TICKS` ticks (1000 ticks, 200 ms, by default). A qualified drop enables the pull-down in the same cycle it qualifies, and a new qualified drop during the hold starts the count again from zero. When another device pulls the shared line low, the falling edge (seen through a synchroniser) starts a pulse of `PULSE_TICKS` ticks, so the line stays low for the longer of that pulse and the external hold. The level of the line never starts a pulse, and the block's own pull-down is masked from the edge detector. A write-lockout flag blocks nonvolatile writes whenever the block pulls the line low or the line is seen low.

Top module: `supv_rst_ctrl`

## Requirements
- R1: While `rstN` is low and after it is released, `pullLow` and `writeLock` are 1 until the power-up hold ends.
- R2: With the supply good, `pullLow` stays 1 through `HOLD_TICKS`-1 ticks after the hold starts and is 0 after the tick numbered `HOLD_TICKS`.
- R3: A supply-low run shorter than `GLITCH_CYCLES` consecutive clock samples has no effect: a released `pullLow` stays 0, and the hold count is not restarted.
- R4: When `supplyOk` has been sampled low on `GLITCH_CYCLES` consecutive rising edges, `pullLow` is 1 directly after that edge, with no added cycle.
- R5: A qualified supply drop during the hold restarts the count, so `HOLD_TICKS` full ticks are needed after the supply returns.
- R6: A 1-to-0 transition of `pinSense` while the line is released sets `pullLow` within three clock edges, and `pullLow` then lasts `PULSE_TICKS` ticks.
- R7: A low level of `pinSense` with no falling edge seen while the line is released (held across the end of a hold, or the rising edge on release) starts no pulse.
- R8: `writeLock` is 1 whenever `pullLow` is 1 or the synchronised `pinSense` is 0, so an external low longer than the pulse keeps it set, and it is 0 otherwise.
- R9: Ending its own pull-down does not retrigger the block: after a pulse or hold ends, `pullLow` stays 0 unless a new supply drop or external edge occurs.
- R10: A qualified supply drop during a manual pulse turns it into a full power-up hold of `HOLD_TICKS` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset of the block's own flops |
| slowTick | input | 1 | One-cycle strobe per 5 kHz oscillator period |
| supplyOk | input | 1 | Digitised comparator, 1 when the supply is above the trip level |
| pinSense | input | 1 | Asynchronous sensed level of the shared reset line |
| pullLow | output | 1 | Pull-down enable of the open-drain reset line, 1 pulls low |
| writeLock | output | 1 | 1 blocks nonvolatile writes |

## Verification
Every cycle the checker confirms that a supply-low run of the filter length has enabled the pull-down, that a qualified drop or a detected external edge always leads to the pull-down, that the lockout covers every cycle of pull-down, that no release comes before the shorter of the two tick limits has elapsed, and that a release is never followed at once by a self-caused retrigger. The exact tick on which a hold or pulse ends, the restart of the hold by a second drop, the lack of effect of short glitches and of pin levels, and the lockout following an external low longer than the pulse are only shown by the bench scenarios, which model the wired line as the AND of the block's pull-down and an external driver.

// File: rtl/supv_rst_pkg.sv
package supv_rst_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PULSE = 2'd2
  } supvState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic cntClr;     // clear the tick counter
    logic cntEn;      // count slow ticks
    logic pulseLimit; // 1: compare against pulse length, 0: hold length
    logic drive;      // pull the reset line low
  } ctlStrobe_t;

endpackage

// File: rtl/supv_rst_datapath.sv
module supv_rst_datapath
  import supv_rst_pkg::*;
#(
  parameter int HOLD_TICKS    = 1000,
  parameter int PULSE_TICKS   = 1000,
  parameter int GLITCH_CYCLES = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slowTick,
  input  logic       supplyOk,
  input  logic       pinSense,
  input  ctlStrobe_t strb,
  output logic       supplyBad,
  output logic       pinFall,
  output logic       cntDone,
  output logic       pinLowSync
);

  localparam int MAX_TICKS = (HOLD_TICKS > PULSE_TICKS) ? HOLD_TICKS : PULSE_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam int GL_W      = $clog2(GLITCH_CYCLES + 1);
  localparam int HIST_LEN  = SYNC_STAGES + 1;
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_TICKS - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_TICKS - 1);
  localparam logic [GL_W-1:0]  GL_LIMIT   = GL_W'(GLITCH_CYCLES);

  // ---------------- supply glitch filter ----------------
  logic [GL_W-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (supplyOk) begin
      lowCnt <= '0;
    end else if (lowCnt != GL_LIMIT) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign supplyBad = (lowCnt == GL_LIMIT);

  // ---------------- reset line synchroniser ----------------
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   pinPrev;
  logic                   pinNow;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= pinSense;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], pinSense};
      end
    end
  endgenerate

  assign pinNow = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 1'b1;
    else       pinPrev <= pinNow;
  end

  assign pinLowSync = ~pinNow;

  // ---------------- own-drive mask for the edge detector ----------------
  logic [HIST_LEN-1:0] driveHist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) driveHist <= '1;
    else       driveHist <= {driveHist[HIST_LEN-2:0], strb.drive};
  end

  assign pinFall = pinPrev & ~pinNow & ~strb.drive & ~(|driveHist);

  // ---------------- slow tick counter ----------------
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] lastVal;
  logic             atLast;

  assign lastVal = strb.pulseLimit ? PULSE_LAST : HOLD_LAST;
  assign atLast  = (tickCnt == lastVal);
  assign cntDone = strb.cntEn & slowTick & atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strb.cntClr) begin
      tickCnt <= '0;
    end else if (strb.cntEn && slowTick) begin
      tickCnt <= atLast ? '0 : tickCnt + 1'b1;
    end
  end

endmodule

// File: rtl/supv_rst_control.sv
module supv_rst_control
  import supv_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyBad,
  input  logic       pinFall,
  input  logic       cntDone,
  output ctlStrobe_t strb
);

  supvState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext       = state;
    strb            = '0;
    // a qualified drop pulls the line in the same cycle
    strb.drive      = (state != ST_RUN) | supplyBad;
    strb.pulseLimit = (state == ST_PULSE);
    unique case (state)
      ST_HOLD: begin
        if (supplyBad) begin
          strb.cntClr = 1'b1;
        end else begin
          strb.cntEn = 1'b1;
          if (cntDone) stateNext = ST_RUN;
        end
      end
      ST_RUN: begin
        if (supplyBad) begin
          strb.cntClr = 1'b1;
          stateNext   = ST_HOLD;
        end else if (pinFall) begin
          strb.cntClr = 1'b1;
          stateNext   = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (supplyBad) begin
          strb.cntClr = 1'b1;
          stateNext   = ST_HOLD;
        end else begin
          strb.cntEn = 1'b1;
          if (cntDone) stateNext = ST_RUN;
        end
      end
      default: begin
        strb.cntClr = 1'b1;
        stateNext   = ST_HOLD;
      end
    endcase
  end

endmodule

// File: rtl/supv_rst_ctrl.sv
module supv_rst_ctrl
  import supv_rst_pkg::*;
#(
  parameter int HOLD_TICKS    = 1000,
  parameter int PULSE_TICKS   = 1000,
  parameter int GLITCH_CYCLES = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic slowTick,
  input  logic supplyOk,
  input  logic pinSense,
  output logic pullLow,
  output logic writeLock
);

  ctlStrobe_t strb;
  logic       supplyBad;
  logic       pinFall;
  logic       cntDone;
  logic       pinLowSync;

  supv_rst_datapath #(
    .HOLD_TICKS   (HOLD_TICKS),
    .PULSE_TICKS  (PULSE_TICKS),
    .GLITCH_CYCLES(GLITCH_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .slowTick  (slowTick),
    .supplyOk  (supplyOk),
    .pinSense  (pinSense),
    .strb      (strb),
    .supplyBad (supplyBad),
    .pinFall   (pinFall),
    .cntDone   (cntDone),
    .pinLowSync(pinLowSync)
  );

  supv_rst_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .supplyBad(supplyBad),
    .pinFall  (pinFall),
    .cntDone  (cntDone),
    .strb     (strb)
  );

  assign pullLow   = strb.drive;
  assign writeLock = strb.drive | pinLowSync;

endmodule

// File: rtl/supv_rst_checker.sv
module supv_rst_checker #(
  parameter int HOLD_TICKS    = 1000,
  parameter int PULSE_TICKS   = 1000,
  parameter int GLITCH_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic slowTick,
  input logic supplyOk,
  input logic pullLow,
  input logic writeLock,
  input logic supplyBad,
  input logic pinFall
);

  localparam int MIN_TICKS = (HOLD_TICKS < PULSE_TICKS) ? HOLD_TICKS : PULSE_TICKS;
  localparam int RT_W      = $clog2(MIN_TICKS + 1);
  localparam int LR_W      = $clog2(GLITCH_CYCLES + 1);

  logic [LR_W-1:0] lowRun;
  logic [RT_W-1:0] relTicks;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               lowRun <= '0;
    else if (supplyOk)                       lowRun <= '0;
    else if (lowRun != LR_W'(GLITCH_CYCLES)) lowRun <= lowRun + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                         relTicks <= '0;
    else if (!pullLow)                                 relTicks <= '0;
    else if (slowTick && relTicks != RT_W'(MIN_TICKS)) relTicks <= relTicks + 1'b1;
  end

  // R4: a low run of filter length pulls the line at once
  a_r4_low_run_drives: assert property (@(posedge clk) disable iff (!rstN)
    (lowRun == LR_W'(GLITCH_CYCLES)) |-> pullLow);

  // R4: the filter's qualified flag always reaches the pull-down
  a_r4_bad_drives: assert property (@(posedge clk) disable iff (!rstN)
    supplyBad |-> pullLow);

  // R6: a detected external edge leads to the pull-down next cycle
  a_r6_edge_pulls: assert property (@(posedge clk) disable iff (!rstN)
    pinFall |=> pullLow);

  // R8: lockout covers every pull-down cycle
  a_r8_lock_covers: assert property (@(posedge clk) disable iff (!rstN)
    pullLow |-> writeLock);

  // R2: no release before the shorter tick limit has elapsed
  a_r2_min_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pullLow) |-> (relTicks == RT_W'(MIN_TICKS)));

  // R9: a release is not followed by a self-caused retrigger
  a_r9_no_self_retrigger: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pullLow) |=> (!pullLow || supplyBad));

endmodule

bind supv_rst_ctrl supv_rst_checker #(
  .HOLD_TICKS   (HOLD_TICKS),
  .PULSE_TICKS  (PULSE_TICKS),
  .GLITCH_CYCLES(GLITCH_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .slowTick (slowTick),
  .supplyOk (supplyOk),
  .pullLow  (pullLow),
  .writeLock(writeLock),
  .supplyBad(supplyBad),
  .pinFall  (pinFall)
);

// File: tb/test_supv_rst_ctrl.sv
module test_supv_rst_ctrl;

  localparam int HOLD   = 20;
  localparam int PULSE  = 8;
  localparam int GLITCH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slowTick = 1'b0;
  logic supplyOk = 1'b1;
  logic extLow = 1'b0;
  logic pinSense;
  logic pullLow;
  logic writeLock;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // wired-AND line: low when either side pulls
  assign pinSense = ~(pullLow | extLow);

  supv_rst_ctrl #(
    .HOLD_TICKS(HOLD), .PULSE_TICKS(PULSE), .GLITCH_CYCLES(GLITCH), .SYNC_STAGES(2)
  ) i_supv_rst_ctrl (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .supplyOk(supplyOk),
    .pinSense(pinSense), .pullLow(pullLow), .writeLock(writeLock)
  );

  function automatic bit expQualified(int lowLen);
    return lowLen >= GLITCH;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      slowTick = 1'b1;
      @(negedge clk);
      slowTick = 1'b0;
      cyc(2);
    end
  endtask

  task automatic supplyDrop(int len);
    supplyOk = 1'b0;
    cyc(len);
    supplyOk = 1'b1;
    cyc(2);
  endtask

  task automatic pinPulse(int len);
    extLow = 1'b1;
    cyc(len);
    extLow = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state
    cyc(3);
    chk("R1 pullLow in reset", pullLow, 1'b1);
    chk("R1 writeLock in reset", writeLock, 1'b1);
    rstN = 1'b1;
    cyc(3);
    chk("R1 pullLow after reset", pullLow, 1'b1);

    // R2: power-up hold length
    tick(HOLD - 1);
    chk("R2 held before last tick", pullLow, 1'b1);
    tick(1);
    chk("R2 released on last tick", pullLow, 1'b0);
    chk("R8 lock cleared", writeLock, 1'b0);

    // R3: random short glitches while released
    for (int i = 0; i < 6; i++) begin
      int len;
      len = 1 + int'($urandom % (GLITCH - 1));
      supplyOk = 1'b0;
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        chk("R3 short glitch ignored", pullLow, 1'b0);
      end
      supplyOk = 1'b1;
      cyc(2);
      chk("R3 after short glitch", pullLow, 1'b0);
    end

    // R4: exact qualification cycle
    supplyOk = 1'b0;
    for (int k = 1; k <= GLITCH; k++) begin
      @(negedge clk);
      chk("R4 qualification edge", pullLow, (k >= GLITCH) ? 1'b1 : 1'b0);
    end
    cyc(5);
    supplyOk = 1'b1;
    cyc(2);
    tick(HOLD - 1);
    chk("R2 hold after brownout", pullLow, 1'b1);
    tick(1);
    chk("R2 release after brownout", pullLow, 1'b0);

    // R3 + R5: glitch does not restart, qualified drop does
    supplyDrop(GLITCH + 2);
    tick(3);
    supplyDrop(GLITCH - 1);
    tick(HOLD - 4);
    chk("R3 glitch in hold kept count", pullLow, 1'b1);
    tick(1);
    chk("R3 hold ended on schedule", pullLow, 1'b0);
    supplyDrop(GLITCH);
    tick(HOLD / 2);
    supplyDrop(GLITCH + 1);
    tick(HOLD - 1);
    chk("R5 restart keeps line low", pullLow, 1'b1);
    tick(1);
    chk("R5 full hold after restart", pullLow, 1'b0);

    // R6 + R9: manual pulse from a short external low
    pinPulse(1);
    cyc(2);
    chk("R6 pulse started", pullLow, 1'b1);
    tick(PULSE - 1);
    chk("R6 pulse held", pullLow, 1'b1);
    tick(1);
    chk("R6 pulse ended", pullLow, 1'b0);
    cyc(10);
    chk("R9 no self retrigger", pullLow, 1'b0);
    chk("R8 lock off after pulse", writeLock, 1'b0);

    // R7 + R8: external low longer than the pulse
    extLow = 1'b1;
    cyc(3);
    chk("R6 long low triggers", pullLow, 1'b1);
    tick(PULSE);
    chk("R6 pulse over while pin low", pullLow, 1'b0);
    chk("R8 lock held by pin", writeLock, 1'b1);
    cyc(10);
    chk("R7 level does not retrigger", pullLow, 1'b0);
    extLow = 1'b0;
    cyc(3);
    chk("R8 lock off after pin release", writeLock, 1'b0);
    cyc(5);
    chk("R7 rising edge no pulse", pullLow, 1'b0);

    // R7: pin held low across the end of a hold
    extLow = 1'b1;
    supplyDrop(GLITCH + 1);
    tick(HOLD);
    chk("R7 hold ends under external low", pullLow, 1'b0);
    chk("R8 lock kept by low pin", writeLock, 1'b1);
    cyc(8);
    chk("R7 no pulse from level", pullLow, 1'b0);
    extLow = 1'b0;
    cyc(8);
    chk("R7 quiet after release", pullLow, 1'b0);

    // R10: brownout during a manual pulse
    pinPulse(1);
    cyc(2);
    tick(2);
    supplyDrop(GLITCH);
    tick(PULSE);
    chk("R10 pulse became hold", pullLow, 1'b1);
    tick(HOLD - PULSE - 1);
    chk("R10 hold still running", pullLow, 1'b1);
    tick(1);
    chk("R10 hold ended", pullLow, 1'b0);

    // random mix of drop lengths
    for (int i = 0; i < 8; i++) begin
      int len;
      bit q;
      len = 1 + int'($urandom % (2 * GLITCH));
      q = expQualified(len);
      supplyDrop(len);
      chk("R4 random drop", pullLow, q ? 1'b1 : 1'b0);
      if (q) begin
        tick(HOLD);
        chk("R2 random recovery", pullLow, 1'b0);
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule